// File: doc/BRIEF.md
# Programmable 32-Input Interrupt Controller

This block gathers thirty-two interrupt request lines and drives two request outputs towards the processor: an ordinary interrupt and a critical interrupt. Software configures each line separately. It sets which level counts as active, whether the line is latched on an edge or followed as a level, whether it is enabled, and which of the two outputs it feeds. A small synchronous register bus reads and writes the configuration. It also reads the request status and clears latched requests.

The block also presents a vector for the pending enabled request that currently has the highest priority. Priority is fixed by input number. One configuration bit chooses which end of the numbering wins. The vector is a software-chosen base plus four times the winning input number, so it can index a table of 32-bit handler addresses directly.

In every 32-bit register, input 0 sits in bit 31 and input 31 sits in bit 0. Register offsets on the bus are: 0 status, 1 enable, 2 critical class, 3 polarity, 4 trigger mode, 5 vector configuration. Offsets 6 and 7 read as zero. Writes to them are ignored.

Top module: `irqc_top`

## Requirements
- R1: After reset, the enable, critical, polarity, trigger and vector configuration registers read 0. Both interrupt outputs are low and the vector output is 0. With every input held high, the status register also reads 0.
- R2: The enable, critical, polarity, trigger and vector configuration registers read back the value last written, through offsets 1 to 5. Input i corresponds to register bit 31-i. Offsets 6 and 7 read 0.
- R3: A polarity bit of 1 makes its input active when high. A polarity bit of 0 makes it active when low.
- R4: A trigger bit of 0 selects level mode. In level mode the status bit reads 1 exactly while the input is at its active level, and writing 1 to that status bit has no effect.
- R5: A trigger bit of 1 selects edge mode. The status bit sets at the clock edge that first sees the input go from inactive to active. It stays set after the input goes inactive, until a 1 is written to it. Writing 0 leaves it unchanged. An input held active after a clear does not set the bit again.
- R6: When an active edge and a write-one clear reach the same edge-mode status bit in the same cycle, the bit ends up set.
- R7: The ordinary output is the OR, over inputs whose critical bit is 0, of status AND enable. The critical output is the same OR over inputs whose critical bit is 1. A disabled input affects neither output.
- R8: When bit 0 of the vector configuration is 1, the lowest-numbered pending enabled input wins. When it is 0, the highest-numbered one wins.
- R9: The vector equals the vector configuration with bit 0 forced to 0, plus 4 times the winning input number. With nothing pending and enabled, the vector equals that base.
- R10: Writing all ones to the status register clears every edge-latched status bit in one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 32 | Interrupt request lines, bit i is input i |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| irq_norm | output | 1 | Ordinary interrupt request |
| irq_crit | output | 1 | Critical interrupt request |
| irq_vec | output | 32 | Vector of the highest-priority pending enabled input |

## Verification
The bench aims at the edge latch where it is easiest to get wrong:
- A request raised and cleared in the same cycle must stay set. A design that lets the clear win would lose that interrupt.
- An input held active after a clear must not set the bit again. A design that latches on level would re-raise the request forever.
- A write of 0 to the status register must leave the bit alone. A design that writes instead of clears would drop pending requests.

The bench also exercises two mapping points:
- The reversed bit order, where input 0 sits in register bit 31. A design with the natural order would report and enable the wrong lines.
- Both priority directions and a base with bit 0 set, which catch an inverted encoder or a vector that is off by one address.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_STAT = 3'd0,
    RA_ENAB = 3'd1,
    RA_CRIT = 3'd2,
    RA_POL  = 3'd3,
    RA_TRIG = 3'd4,
    RA_VCFG = 3'd5
  } reg_addr_e;

endpackage

// File: rtl/irqc_capture.sv
// Per-input active-level detection and edge latching.
module irqc_capture #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] pol,
  input  logic [N_SRC-1:0] trig,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] status_view
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic act;
    logic act_q;
    logic edge_hit;
    logic latch_q;
    logic latch_d;

    // Active level after polarity
    assign act      = pol[i] ? irq_in[i] : ~irq_in[i];
    assign edge_hit = act & ~act_q;

    // Next state: a new edge wins over a clear in the same cycle
    always_comb begin
      if (!trig[i])      latch_d = 1'b0;
      else if (edge_hit) latch_d = 1'b1;
      else if (clr[i])   latch_d = 1'b0;
      else               latch_d = latch_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q   <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        act_q   <= act;
        latch_q <= latch_d;
      end
    end

    assign status_view[i] = trig[i] ? latch_q : act;
  end

endmodule

// File: rtl/irqc_regs.sv
// Configuration registers and the bus view, with input i at bit DATA_W-1-i.
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N_SRC-1:0]  status_view,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  crit_o,
  output logic [N_SRC-1:0]  pol_o,
  output logic [N_SRC-1:0]  trig_o,
  output logic [DATA_W-1:0] vcfg_o,
  output logic [N_SRC-1:0]  clr_o
);

  logic              we;
  logic              re;
  logic              stat_ce, en_ce, crit_ce, pol_ce, trig_ce, vcfg_ce;
  logic [N_SRC-1:0]  wsrc;
  logic [N_SRC-1:0]  en_q, crit_q, pol_q, trig_q;
  logic [DATA_W-1:0] vcfg_q;
  logic [DATA_W-1:0] stat_rv, en_rv, crit_rv, pol_rv, trig_rv;

  // Strobes and clock enables
  always_comb begin
    we      = bus_sel &  bus_wr;
    re      = bus_sel & ~bus_wr;
    stat_ce = we && (bus_addr == RA_STAT);
    en_ce   = we && (bus_addr == RA_ENAB);
    crit_ce = we && (bus_addr == RA_CRIT);
    pol_ce  = we && (bus_addr == RA_POL);
    trig_ce = we && (bus_addr == RA_TRIG);
    vcfg_ce = we && (bus_addr == RA_VCFG);
  end

  // Bit reversal between input numbering and the register view
  always_comb begin
    wsrc    = '0;
    stat_rv = '0;
    en_rv   = '0;
    crit_rv = '0;
    pol_rv  = '0;
    trig_rv = '0;
    for (int i = 0; i < N_SRC; i++) begin
      wsrc[i]              = bus_wdata[DATA_W-1-i];
      stat_rv[DATA_W-1-i]  = status_view[i];
      en_rv[DATA_W-1-i]    = en_q[i];
      crit_rv[DATA_W-1-i]  = crit_q[i];
      pol_rv[DATA_W-1-i]   = pol_q[i];
      trig_rv[DATA_W-1-i]  = trig_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
      vcfg_q <= '0;
    end else begin
      if (en_ce)   en_q   <= wsrc;
      if (crit_ce) crit_q <= wsrc;
      if (pol_ce)  pol_q  <= wsrc;
      if (trig_ce) trig_q <= wsrc;
      if (vcfg_ce) vcfg_q <= bus_wdata;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (re) begin
      case (bus_addr)
        RA_STAT: bus_rdata = stat_rv;
        RA_ENAB: bus_rdata = en_rv;
        RA_CRIT: bus_rdata = crit_rv;
        RA_POL:  bus_rdata = pol_rv;
        RA_TRIG: bus_rdata = trig_rv;
        RA_VCFG: bus_rdata = vcfg_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign clr_o  = stat_ce ? wsrc : '0;
  assign en_o   = en_q;
  assign crit_o = crit_q;
  assign pol_o  = pol_q;
  assign trig_o = trig_q;
  assign vcfg_o = vcfg_q;

endmodule

// File: rtl/irqc_prio.sv
// Fixed-priority encoder with selectable direction and vector formation.
module irqc_prio #(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32
) (
  input  logic [N_SRC-1:0]  pend,
  input  logic [DATA_W-1:0] vcfg,
  output logic [DATA_W-1:0] vec
);

  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic              low_first;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] offs;

  assign low_first = vcfg[0];
  assign base      = {vcfg[DATA_W-1:1], 1'b0};

  // The last match in scan order wins
  always_comb begin
    idx = '0;
    if (low_first) begin
      for (int i = N_SRC - 1; i >= 0; i--)
        if (pend[i]) idx = IDX_W'(i);
    end else begin
      for (int i = 0; i < N_SRC; i++)
        if (pend[i]) idx = IDX_W'(i);
    end
  end

  assign offs = {{(DATA_W-IDX_W){1'b0}}, idx} << 2;
  assign vec  = base + offs;

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_norm,
  output logic              irq_crit,
  output logic [DATA_W-1:0] irq_vec
);

  logic [1:0]        rst_sync_q;
  logic              srst_n;
  logic [N_SRC-1:0]  en_w, crit_w, pol_w, trig_w, clr_w;
  logic [N_SRC-1:0]  status_w;
  logic [N_SRC-1:0]  pend_w;
  logic [DATA_W-1:0] vcfg_w;

  // Reset asserts at once and releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  irqc_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (srst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .status_view (status_w),
    .bus_rdata   (bus_rdata),
    .en_o        (en_w),
    .crit_o      (crit_w),
    .pol_o       (pol_w),
    .trig_o      (trig_w),
    .vcfg_o      (vcfg_w),
    .clr_o       (clr_w)
  );

  irqc_capture #(.N_SRC(N_SRC)) u_cap (
    .clk         (clk),
    .rst_n       (srst_n),
    .irq_in      (irq_in),
    .pol         (pol_w),
    .trig        (trig_w),
    .clr         (clr_w),
    .status_view (status_w)
  );

  assign pend_w   = status_w & en_w;
  assign irq_norm = |(pend_w & ~crit_w);
  assign irq_crit = |(pend_w &  crit_w);

  irqc_prio #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_prio (
    .pend (pend_w),
    .vcfg (vcfg_w),
    .vec  (irq_vec)
  );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int N_SRC  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_norm,
  input logic              irq_crit,
  input logic [DATA_W-1:0] irq_vec,
  input logic [N_SRC-1:0]  en,
  input logic [N_SRC-1:0]  trig,
  input logic [N_SRC-1:0]  status,
  input logic [N_SRC-1:0]  clr,
  input logic [DATA_W-1:0] vcfg
);

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_norm && !irq_crit && irq_vec == '0));

  // R7
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (!irq_norm && !irq_crit));

  // R9
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_norm && !irq_crit) |-> (irq_vec == {vcfg[DATA_W-1:1], 1'b0}));

  // R9
  vec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vec[1:0] == {vcfg[1], 1'b0});

  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig == $past(trig)) |->
      (($past(status) & trig & ~$past(clr) & ~status) == '0));

endmodule

bind irqc_top irqc_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .irq_norm (irq_norm),
  .irq_crit (irq_crit),
  .irq_vec  (irq_vec),
  .en       (en_w),
  .trig     (trig_w),
  .status   (status_w),
  .clr      (clr_w),
  .vcfg     (vcfg_w)
);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_norm, irq_crit;
  logic [31:0] irq_vec;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] A_STAT = 3'd0, A_EN = 3'd1, A_CRIT = 3'd2,
                         A_POL = 3'd3, A_TRIG = 3'd4, A_VCFG = 3'd5;

  always #5 clk = ~clk;

  irqc_top uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_norm(irq_norm), .irq_crit(irq_crit), .irq_vec(irq_vec)
  );

  // Level-mode vectors: registers in bus view, irq_in by input number
  typedef struct packed {
    logic [31:0] pol;
    logic [31:0] en;
    logic [31:0] crit;
    logic [31:0] vcfg;
    logic [31:0] irq;
    logic [31:0] stat;
    logic        exp_n;
    logic        exp_c;
    logic [31:0] vec;
  } tv_t;

  localparam tv_t TBL [6] = '{
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0000_1001, 32'h0000_0408, 32'h1020_0000, 1'b1, 1'b0, 32'h0000_100C},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0000_1000, 32'h0000_0408, 32'h1020_0000, 1'b1, 1'b0, 32'h0000_1028},
    '{32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_2001, 32'hFFFF_FFFE, 32'h8000_0000, 1'b0, 1'b1, 32'h0000_2000},
    '{32'hFFFF_FFFF, 32'h0100_0000, 32'h0, 32'h0000_0301, 32'h0000_0084, 32'h2100_0000, 1'b1, 1'b0, 32'h0000_031C},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0041, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b1, 32'h0000_00BC},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0000_0555, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0000_0554}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; irq_in = '1; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 reg %0d", a), d, 32'h0);
    end
    chk("R1 irq_norm", {31'b0, irq_norm}, 32'h0);
    chk("R1 irq_crit", {31'b0, irq_crit}, 32'h0);
    chk("R1 vector", irq_vec, 32'h0);

    // Table walk, level mode: R3 R7 R8 R9
    for (int k = 0; k < 6; k++) begin
      wr(A_POL, TBL[k].pol);
      wr(A_EN, TBL[k].en);
      wr(A_CRIT, TBL[k].crit);
      wr(A_VCFG, TBL[k].vcfg);
      irq_in = TBL[k].irq;
      #1;
      chk($sformatf("R7 norm vec%0d", k), {31'b0, irq_norm}, {31'b0, TBL[k].exp_n});
      chk($sformatf("R7 crit vec%0d", k), {31'b0, irq_crit}, {31'b0, TBL[k].exp_c});
      chk($sformatf("R8 R9 vector vec%0d", k), irq_vec, TBL[k].vec);
      rd(A_STAT, d);
      chk($sformatf("R3 status vec%0d", k), d, TBL[k].stat);
    end

    // R2 readback and unmapped offsets
    wr(A_EN, 32'h1234_5678); rd(A_EN, d); chk("R2 enable readback", d, 32'h1234_5678);
    wr(A_VCFG, 32'hDEAD_BEEF); rd(A_VCFG, d); chk("R2 vcfg readback", d, 32'hDEAD_BEEF);
    rd(3'd6, d); chk("R2 offset 6", d, 32'h0);
    rd(3'd7, d); chk("R2 offset 7", d, 32'h0);

    // Edge mode on input 4 (register bit 27)
    irq_in = '0;
    wr(A_POL, 32'hFFFF_FFFF);
    wr(A_EN, 32'h0800_0000);
    wr(A_CRIT, 32'h0);
    wr(A_VCFG, 32'h1);
    wr(A_TRIG, 32'h0800_0000);
    @(negedge clk); irq_in[4] = 1'b1;
    @(negedge clk); irq_in[4] = 1'b0;
    rd(A_STAT, d); chk("R5 latched after pulse", d, 32'h0800_0000);
    chk("R5 norm from latch", {31'b0, irq_norm}, 32'h1);
    chk("R9 vector input 4", irq_vec, 32'h0000_0010);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R5 write zero keeps", d, 32'h0800_0000);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, d); chk("R10 clear all", d, 32'h0);
    chk("R10 norm after clear", {31'b0, irq_norm}, 32'h0);

    // R5 held input does not relatch after clear
    @(negedge clk); irq_in[4] = 1'b1;
    @(negedge clk);
    wr(A_STAT, 32'h0800_0000);
    rd(A_STAT, d); chk("R5 held no relatch", d, 32'h0);
    @(negedge clk); irq_in[4] = 1'b0;

    // R6 edge and clear in the same cycle
    @(negedge clk); irq_in[4] = 1'b1;
    @(negedge clk); irq_in[4] = 1'b0;
    @(negedge clk);
    irq_in[4] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h0800_0000;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; irq_in[4] = 1'b0;
    rd(A_STAT, d); chk("R6 set wins over clear", d, 32'h0800_0000);

    // R4 level mode ignores clears and follows the input
    wr(A_TRIG, 32'h0);
    @(negedge clk); irq_in[4] = 1'b1;
    rd(A_STAT, d); chk("R4 level active", d, 32'h0800_0000);
    wr(A_STAT, 32'h0800_0000);
    rd(A_STAT, d); chk("R4 clear ignored", d, 32'h0800_0000);
    @(negedge clk); irq_in[4] = 1'b0;
    rd(A_STAT, d); chk("R4 level follows low", d, 32'h0);

    // R3 active-low input 0 (bit 31), enable mapping R2
    wr(A_POL, 32'h7FFF_FFFF);
    wr(A_EN, 32'h8000_0000);
    rd(A_STAT, d); chk("R3 active low input 0", d, 32'h8000_0000);
    chk("R2 bit31 enables input 0", {31'b0, irq_norm}, 32'h1);
    chk("R9 vector input 0", irq_vec, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule